// File: doc/BRIEF.md
# Flag-Aware Byte ALU with Memory Write-Back Target

This block is the arithmetic and logic unit of a small 8-bit processor core. Every cycle it may accept one operation: a 4-bit operation code, two operands, the incoming N, V, Z and C flags, and two mode bits. The mode bits are a write-back selector and a decimal selector. One cycle later it presents a registered result, a code that names where the result belongs, and the updated flags.

With the write-back selector clear, the two-operand operations combine the accumulator (`opnd_a`) with a memory operand (`opnd_m`), and their result is tagged for the accumulator. With the selector set, the sequencer feeds the byte at the address held in the X index register through `opnd_a`. The result is then tagged to be written back to that same byte, and the accumulator is left alone. The single-operand operations work on either the accumulator or the memory operand. The complement and half-swap operations always work on the memory operand. Address generation and the memory cycles belong to the surrounding sequencer.

With the decimal selector set, add and subtract treat each 4-bit group as a BCD digit. They correct the digit sums and take C from the decimal carry. N, V and Z after those two operations carry no defined meaning.

Top module: `mt_alu`

## Requirements
- R1: Outputs are registered. `res_valid` in a cycle equals `op_valid` of the previous cycle. A synchronous active-high reset clears `res_valid`, `res_data`, all four flag outputs and `res_dest` (to 0).
- R2: `res_dest` encodes the target as 0 = none, 1 = accumulator, 2 = X-addressed memory byte, 3 = memory operand. Codes 0..5 give 2 when `mem_mode`=1 and 1 otherwise. Codes 6 and 7 give 0. Codes 8 and 15 give 3. Codes 9..14 give 3 when `unary_on_mem`=1 and 1 otherwise.
- R3: Code 0 (add) returns `opnd_a + opnd_m + carry_in` modulo 2^WIDTH. C is the carry out of the top bit. V is set when both operands have the same sign bit and the result's sign bit differs from it.
- R4: Code 1 (subtract) returns `opnd_a - opnd_m - (1 - carry_in)` modulo 2^WIDTH. C=1 means no borrow. V is set when the operand signs differ and the result's sign differs from `opnd_a`.
- R5: Codes 2, 3, 4 and 5 return AND, OR, XOR and a plain copy of `opnd_m`. V and C pass through unchanged.
- R6: Code 6 (compare) returns `opnd_a - opnd_m` modulo 2^WIDTH. C = (`opnd_a` >= `opnd_m` unsigned). V passes through.
- R7: Code 7 (bit test) returns `opnd_a & opnd_m`. N is the top bit of `opnd_m`, V is the bit below it, and Z is set when the AND is zero. C passes through.
- R8: Code 8 returns the one's complement of `opnd_m`. V and C pass through.
- R9: Codes 9 and 10 add and subtract one on the selected single operand. V and C pass through.
- R10: Code 11 shifts left with 0 into bit 0, and code 12 shifts right with 0 into the top bit. The bit shifted out goes to C. V passes through.
- R11: Code 13 rotates left with `carry_in` into bit 0, and code 14 rotates right with `carry_in` into the top bit. The bit shifted out goes to C. V passes through.
- R12: Code 15 rotates `opnd_m` right by WIDTH/2 bit positions. All four flags pass through unchanged.
- R13: With `dec_mode`=1, codes 0 and 1 treat each 4-bit group as a decimal digit. They return the decimal sum or difference modulo 10^(WIDTH/4), with C = decimal carry out for add and C = no decimal borrow for subtract. For these two codes, N, V and Z are left unspecified.
- R14: For codes 0..6 and 8..14 (outside the decimal case of R13), N is the top bit of the result and Z is set exactly when the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see R2..R12) |
| opnd_a | input | WIDTH | Accumulator, or the X-addressed byte when `mem_mode`=1 |
| opnd_m | input | WIDTH | Memory operand |
| mem_mode | input | 1 | Write-back selector for codes 0..5 |
| dec_mode | input | 1 | Decimal selector for add and subtract |
| unary_on_mem | input | 1 | Codes 9..14 work on `opnd_m` instead of `opnd_a` |
| carry_in | input | 1 | Incoming C flag |
| ovf_in | input | 1 | Incoming V flag |
| neg_in | input | 1 | Incoming N flag |
| zero_in | input | 1 | Incoming Z flag |
| res_valid | output | 1 | Result present |
| res_data | output | WIDTH | Result value |
| res_dest | output | 2 | Write-back target code |
| flag_n | output | 1 | Updated N |
| flag_v | output | 1 | Updated V |
| flag_z | output | 1 | Updated Z |
| flag_c | output | 1 | Updated C |

## Verification
The bench builds the ALU with WIDTH=4, so each operand is a single digit. Every code meets every pair of operands, both carry values and mixed mode bits, and the expected result, flags and target come from plain integer arithmetic. At that width the BCD path reduces to one digit, so all hundred valid digit pairs can be tried for add and subtract with both carries. That covers every decimal carry and borrow boundary, along with every signed-overflow and half-swap case.

// File: rtl/mt_alu_pkg.sv
package mt_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_LOAD = 4'd5,
    OP_CMP  = 4'd6,
    OP_BTST = 4'd7,
    OP_COM  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_ASL  = 4'd11,
    OP_LSR  = 4'd12,
    OP_ROL  = 4'd13,
    OP_ROR  = 4'd14,
    OP_SWAP = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_ACC  = 2'd1,
    DST_MEMX = 2'd2,
    DST_MEM  = 2'd3
  } alu_dst_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_OR   = 2'd1,
    LG_XOR  = 2'd2,
    LG_PASS = 2'd3
  } logic_sel_e;

endpackage

// File: rtl/mt_alu_addsub.sv
module mt_alu_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] m,
  input  logic             cin,
  input  logic             sub,
  input  logic             dec,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int NDIG = WIDTH / 4;

  logic [WIDTH-1:0] m_eff;
  logic [WIDTH:0]   bin_full;
  logic [WIDTH-1:0] dec_sum;
  logic             dec_cy;

  assign m_eff    = sub ? ~m : m;
  assign bin_full = {1'b0, a} + {1'b0, m_eff} + {{WIDTH{1'b0}}, cin};

  // Digit-serial BCD chain; for subtract the chain carries a borrow.
  always_comb begin
    logic       chain;
    logic [3:0] ad;
    logic [3:0] md;
    logic [4:0] raw;
    chain   = sub ? ~cin : cin;
    dec_sum = '0;
    for (int g = 0; g < NDIG; g++) begin
      ad = a[4*g +: 4];
      md = m[4*g +: 4];
      if (!sub) begin
        raw   = {1'b0, ad} + {1'b0, md} + {4'b0000, chain};
        chain = (raw > 5'd9);
        dec_sum[4*g +: 4] = chain ? (raw[3:0] + 4'd6) : raw[3:0];
      end else begin
        raw   = {1'b0, ad} - {1'b0, md} - {4'b0000, chain};
        chain = raw[4];
        dec_sum[4*g +: 4] = chain ? (raw[3:0] + 4'd10) : raw[3:0];
      end
    end
    dec_cy = sub ? ~chain : chain;
  end

  always_comb begin
    if (dec) begin
      sum  = dec_sum;
      cout = dec_cy;
    end else begin
      sum  = bin_full[WIDTH-1:0];
      cout = bin_full[WIDTH];
    end
    ovf = (a[WIDTH-1] == m_eff[WIDTH-1]) && (bin_full[WIDTH-1] != a[WIDTH-1]);
  end

endmodule

// File: rtl/mt_alu_logic.sv
module mt_alu_logic
  import mt_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] m,
  input  logic_sel_e       sel,
  output logic [WIDTH-1:0] r
);
  // One generate slice per bit keeps each result bit a 4:1 mux.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      unique case (sel)
        LG_AND:  r[b] = a[b] & m[b];
        LG_OR:   r[b] = a[b] | m[b];
        LG_XOR:  r[b] = a[b] ^ m[b];
        default: r[b] = m[b];
      endcase
    end
  end

endmodule

// File: rtl/mt_alu_unary.sv
module mt_alu_unary
  import mt_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic             cin,
  input  alu_op_e          op,
  output logic [WIDTH-1:0] r,
  output logic             cout
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] swapped;

  if (HALF > 0) begin : g_swap
    assign swapped = {x[HALF-1:0], x[WIDTH-1:HALF]};
  end else begin : g_noswap
    assign swapped = x;
  end

  always_comb begin
    r    = x;
    cout = cin;
    unique case (op)
      OP_COM:  r = ~x;
      OP_INC:  r = x + {{(WIDTH-1){1'b0}}, 1'b1};
      OP_DEC:  r = x - {{(WIDTH-1){1'b0}}, 1'b1};
      OP_ASL: begin r = {x[WIDTH-2:0], 1'b0}; cout = x[WIDTH-1]; end
      OP_LSR: begin r = {1'b0, x[WIDTH-1:1]}; cout = x[0];       end
      OP_ROL: begin r = {x[WIDTH-2:0], cin};  cout = x[WIDTH-1]; end
      OP_ROR: begin r = {cin, x[WIDTH-1:1]};  cout = x[0];       end
      OP_SWAP: r = swapped;
      default: r = x;
    endcase
  end

endmodule

// File: rtl/mt_alu.sv
module mt_alu
  import mt_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_m,
  input  logic             mem_mode,
  input  logic             dec_mode,
  input  logic             unary_on_mem,
  input  logic             carry_in,
  input  logic             ovf_in,
  input  logic             neg_in,
  input  logic             zero_in,
  output logic             res_valid,
  output logic [WIDTH-1:0] res_data,
  output logic [1:0]       res_dest,
  output logic             flag_n,
  output logic             flag_v,
  output logic             flag_z,
  output logic             flag_c
);
  localparam int MSB = WIDTH - 1;

  alu_op_e    op;
  logic_sel_e lsel;
  logic       is_sub;
  logic       as_dec;
  logic       as_cin;

  logic [WIDTH-1:0] as_sum, lg_r, un_r, un_x;
  logic             as_cout, as_ovf, un_cout;

  logic [WIDTH-1:0] nx_data;
  alu_dst_e         nx_dest;
  logic             nx_n, nx_v, nx_z, nx_c;

  assign op = alu_op_e'(op_code);

  // Compare shares the adder as a carry-in-one binary subtract.
  assign is_sub = (op == OP_SUB) || (op == OP_CMP);
  assign as_dec = dec_mode && (op != OP_CMP);
  assign as_cin = (op == OP_CMP) ? 1'b1 : carry_in;

  always_comb begin
    unique case (op)
      OP_AND:  lsel = LG_AND;
      OP_OR:   lsel = LG_OR;
      OP_XOR:  lsel = LG_XOR;
      OP_BTST: lsel = LG_AND;
      default: lsel = LG_PASS;
    endcase
  end

  assign un_x = ((op == OP_COM) || (op == OP_SWAP) || unary_on_mem) ? opnd_m : opnd_a;

  mt_alu_addsub #(.WIDTH(WIDTH)) addsub_i (
    .a    (opnd_a),
    .m    (opnd_m),
    .cin  (as_cin),
    .sub  (is_sub),
    .dec  (as_dec),
    .sum  (as_sum),
    .cout (as_cout),
    .ovf  (as_ovf)
  );

  mt_alu_logic #(.WIDTH(WIDTH)) logic_i (
    .a   (opnd_a),
    .m   (opnd_m),
    .sel (lsel),
    .r   (lg_r)
  );

  mt_alu_unary #(.WIDTH(WIDTH)) unary_i (
    .x    (un_x),
    .cin  (carry_in),
    .op   (op),
    .r    (un_r),
    .cout (un_cout)
  );

  // Result, flag and target selection.
  always_comb begin
    nx_data = un_r;
    nx_v    = ovf_in;
    nx_c    = carry_in;
    nx_n    = un_r[MSB];
    nx_z    = (un_r == '0);
    nx_dest = unary_on_mem ? DST_MEM : DST_ACC;
    unique case (op)
      OP_ADD, OP_SUB: begin
        nx_data = as_sum;
        nx_c    = as_cout;
        nx_v    = as_ovf;
        nx_n    = as_sum[MSB];
        nx_z    = (as_sum == '0);
        nx_dest = mem_mode ? DST_MEMX : DST_ACC;
      end
      OP_AND, OP_OR, OP_XOR, OP_LOAD: begin
        nx_data = lg_r;
        nx_n    = lg_r[MSB];
        nx_z    = (lg_r == '0);
        nx_dest = mem_mode ? DST_MEMX : DST_ACC;
      end
      OP_CMP: begin
        nx_data = as_sum;
        nx_c    = as_cout;
        nx_n    = as_sum[MSB];
        nx_z    = (as_sum == '0);
        nx_dest = DST_NONE;
      end
      OP_BTST: begin
        nx_data = lg_r;
        nx_n    = opnd_m[MSB];
        nx_v    = opnd_m[MSB-1];
        nx_z    = (lg_r == '0);
        nx_dest = DST_NONE;
      end
      OP_COM: begin
        nx_dest = DST_MEM;
      end
      OP_SWAP: begin
        nx_n    = neg_in;
        nx_z    = zero_in;
        nx_dest = DST_MEM;
      end
      default: begin
        nx_c = un_cout;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_dest  <= DST_NONE;
      flag_n    <= 1'b0;
      flag_v    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_data <= nx_data;
        res_dest <= nx_dest;
        flag_n   <= nx_n;
        flag_v   <= nx_v;
        flag_z   <= nx_z;
        flag_c   <= nx_c;
      end
    end
  end

endmodule

// File: rtl/mt_alu_chk.sv
module mt_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [3:0]       op_code,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_m,
  input logic             mem_mode,
  input logic             dec_mode,
  input logic             carry_in,
  input logic             ovf_in,
  input logic             neg_in,
  input logic             zero_in,
  input logic             res_valid,
  input logic [WIDTH-1:0] res_data,
  input logic [1:0]       res_dest,
  input logic             flag_n,
  input logic             flag_v,
  input logic             flag_z,
  input logic             flag_c
);
  logic two_op, nz_defined;
  assign two_op     = (op_code <= 4'd5);
  assign nz_defined = (op_code != 4'd7) && (op_code != 4'd15) &&
                      !(dec_mode && (op_code <= 4'd1));

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);
  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid);
  assert_memx_target_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && two_op && mem_mode) |=> (res_dest == 2'd2));
  assert_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 4'd6 || op_code == 4'd7)) |=> (res_dest == 2'd0));
  assert_cmp_carry_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd6) |=> (flag_c == ($past(opnd_a) >= $past(opnd_m))));
  assert_btst_nv_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd7) |=>
      (flag_n == $past(opnd_m[WIDTH-1]) && flag_v == $past(opnd_m[WIDTH-2])));
  assert_swap_flags_R12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd15) |=>
      (flag_c == $past(carry_in) && flag_v == $past(ovf_in) &&
       flag_n == $past(neg_in) && flag_z == $past(zero_in)));
  assert_zero_flag_R14: assert property (@(posedge clk) disable iff (rst)
    (op_valid && nz_defined) |=> (flag_z == (res_data == '0)));
  assert_neg_flag_R14: assert property (@(posedge clk) disable iff (rst)
    (op_valid && nz_defined) |=> (flag_n == res_data[WIDTH-1]));

endmodule

bind mt_alu mt_alu_chk #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .opnd_a    (opnd_a),
  .opnd_m    (opnd_m),
  .mem_mode  (mem_mode),
  .dec_mode  (dec_mode),
  .carry_in  (carry_in),
  .ovf_in    (ovf_in),
  .neg_in    (neg_in),
  .zero_in   (zero_in),
  .res_valid (res_valid),
  .res_data  (res_data),
  .res_dest  (res_dest),
  .flag_n    (flag_n),
  .flag_v    (flag_v),
  .flag_z    (flag_z),
  .flag_c    (flag_c)
);

// File: tb/mt_alu_tb_top.sv
`timescale 1ns/1ps
module mt_alu_tb_top;
  localparam int W = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst, op_valid, mem_mode, dec_mode, unary_on_mem;
  logic         carry_in, ovf_in, neg_in, zero_in;
  logic [3:0]   op_code;
  logic [W-1:0] opnd_a, opnd_m;
  logic         res_valid, flag_n, flag_v, flag_z, flag_c;
  logic [W-1:0] res_data;
  logic [1:0]   res_dest;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  mt_alu #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_m(opnd_m), .mem_mode(mem_mode), .dec_mode(dec_mode),
    .unary_on_mem(unary_on_mem), .carry_in(carry_in), .ovf_in(ovf_in),
    .neg_in(neg_in), .zero_in(zero_in), .res_valid(res_valid),
    .res_data(res_data), .res_dest(res_dest), .flag_n(flag_n),
    .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s op=%0d a=%0d m=%0d c=%0d t=%0d d=%0d actual=%0d expected=%0d",
               req, what, op_code, opnd_a, opnd_m, carry_in, mem_mode, dec_mode, act, exp);
    end
  endtask

  int e_r, e_n, e_v, e_z, e_c, e_d;
  bit e_nvz;

  // Integer reference for one operation at WIDTH=4.
  task automatic model(input int op, input int a, input int m, input int c,
                       input int vi, input int ni, input int zi,
                       input int t, input int d, input int u);
    int x, s;
    e_v = vi; e_c = c; e_nvz = 1;
    x = u ? m : a;
    case (op)
      0: if (d) begin s = a + m + c; e_c = (s >= 10); e_r = s % 10; e_nvz = 0; end
         else begin s = a + m + c; e_r = s & 15; e_c = s >> 4;
                    e_v = ((((a ^ e_r) & (m ^ e_r)) & 8) != 0); end
      1: if (d) begin s = a - m - (1 - c); e_c = (s >= 0); e_r = (s < 0) ? s + 10 : s; e_nvz = 0; end
         else begin s = a + (15 - m) + c; e_r = s & 15; e_c = s >> 4;
                    e_v = ((((a ^ m) & (a ^ e_r)) & 8) != 0); end
      2: e_r = a & m;
      3: e_r = a | m;
      4: e_r = a ^ m;
      5: e_r = m;
      6: begin e_r = (a - m) & 15; e_c = (a >= m); end
      7: e_r = a & m;
      8: e_r = 15 - m;
      9: e_r = (x + 1) & 15;
      10: e_r = (x + 15) & 15;
      11: begin e_r = (x << 1) & 15; e_c = (x >> 3) & 1; end
      12: begin e_r = x >> 1; e_c = x & 1; end
      13: begin e_r = ((x << 1) & 15) | c; e_c = (x >> 3) & 1; end
      14: begin e_r = (x >> 1) | (c << 3); e_c = x & 1; end
      default: e_r = ((m >> 2) | (m << 2)) & 15;
    endcase
    e_n = (e_r >> 3) & 1;
    e_z = (e_r == 0);
    if (op == 7) begin e_n = (m >> 3) & 1; e_v = (m >> 2) & 1; end
    if (op == 15) begin e_n = ni; e_z = zi; end
    if (op <= 5) e_d = t ? 2 : 1;
    else if (op <= 7) e_d = 0;
    else if (op == 8 || op == 15) e_d = 3;
    else e_d = u ? 3 : 1;
  endtask

  function automatic string req_of(input int op, input int d);
    if (d) return "R13";
    case (op)
      0: return "R3";   1: return "R4";
      2, 3, 4, 5: return "R5";
      6: return "R6";   7: return "R7";   8: return "R8";
      9, 10: return "R9";  11, 12: return "R10";  13, 14: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic run_op(input int op, input int a, input int m, input int c, input int d);
    int t, u, vi, ni, zi;
    t = (a + m) & 1; u = ((a ^ m) >> 1) & 1;
    vi = (a ^ (m >> 3)) & 1; ni = (a >> 1) & 1; zi = m & 1;
    @(negedge clk);
    op_valid = 1'b1; op_code = op[3:0]; opnd_a = a[W-1:0]; opnd_m = m[W-1:0];
    carry_in = c[0]; mem_mode = t[0]; dec_mode = d[0]; unary_on_mem = u[0];
    ovf_in = vi[0]; neg_in = ni[0]; zero_in = zi[0];
    model(op, a, m, c, vi, ni, zi, t, d, u);
    @(negedge clk);
    check("R1", "valid", int'(res_valid), 1);
    check("R2", "dest", int'(res_dest), e_d);
    check(req_of(op, d), "data", int'(res_data), e_r);
    check(req_of(op, d), "carry", int'(flag_c), e_c);
    if (e_nvz) begin
      check(req_of(op, d), "ovf", int'(flag_v), e_v);
      check((op == 7 || op == 15) ? req_of(op, d) : "R14", "neg", int'(flag_n), e_n);
      check((op == 7 || op == 15) ? req_of(op, d) : "R14", "zero", int'(flag_z), e_z);
    end
  endtask

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_code = '0; opnd_a = '0; opnd_m = '0;
    mem_mode = 1'b0; dec_mode = 1'b0; unary_on_mem = 1'b0;
    carry_in = 1'b0; ovf_in = 1'b0; neg_in = 1'b0; zero_in = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset valid", int'(res_valid), 0);
    check("R1", "reset dest", int'(res_dest), 0);
    check("R1", "reset data", int'(res_data), 0);
    check("R1", "reset flags", int'({flag_n, flag_v, flag_z, flag_c}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "idle valid", int'(res_valid), 0);

    // Binary sweep of all codes: R2..R12, R14
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int m = 0; m < 16; m++)
          for (int c = 0; c < 2; c++)
            run_op(op, a, m, c, 0);

    // Decimal sweep over valid digits: R13
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 10; a++)
        for (int m = 0; m < 10; m++)
          for (int c = 0; c < 2; c++)
            run_op(op, a, m, c, 1);

    // R1: result valid drops one cycle after the request does
    @(negedge clk);
    op_valid = 1'b0;
    @(negedge clk);
    check("R1", "drop valid", int'(res_valid), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule